// File: doc/BRIEF.md
# Synchronous Serial Port Master with Register Interface

This block is a bus-attached serial master. Software reaches it through a word-addressed register port: it sets the word width and the serial clock rate, queues words for sending in an eight-entry transmit queue, and collects received words from an eight-entry receive queue. A transfer engine takes the oldest transmit word, shifts it out on the serial pins (clock idles low, data launched on the falling edge and sampled on the rising edge, most significant bit first, select held low for the whole word), and stores the word captured on the input pin into the receive queue. When internal loopback is selected the engine skips the pins and copies each word straight from the transmit queue into the receive queue, one word per cycle.

The engine never overruns the receive queue: it only starts a word while the receive queue has a free slot, and it waits otherwise until software reads a word. Status flags and two level-derived interrupt sources (receive queue at least half full, transmit queue at most half full) describe the queues; a mask selects which sources drive the single interrupt line. The slave-select bit of the second control register is accepted and stored, but while it is set no transfer starts.

Top module: `ssp_ctrl`

## Requirements
- R1: After reset the status register (word address 3, byte offset 0x0C) reads 0x03 (transmit empty, transmit not full), raw interrupt status (0x18) reads 0x08, the mask (0x14) reads 0 and `irq` is low.
- R2: Control register 0 (0x00) bits [3:0] = n set the word width to n+1 bits; every word written to the transmit queue and every word stored into the receive queue is truncated to that width.
- R3: Control register 1 (0x04) bit 1 enables the port; while it is clear no word leaves the transmit queue.
- R4: A data write (0x08) while the transmit queue holds 8 words is dropped; a data read with the receive queue empty returns 0.
- R5: A word is moved only while the transmit queue is non-empty and the receive queue holds fewer than 8 words; a full receive queue stalls the engine until a data read frees a slot, and words come out in the order written.
- R6: With control register 1 bit 0 set (loopback) each transmitted word enters the receive queue unchanged; with it clear the word sampled from `miso` during the transfer is stored.
- R7: Status bits: bit 0 transmit empty, bit 1 transmit not full, bit 2 receive not empty, bit 3 receive full, bit 4 busy, where busy equals transmit queue non-empty.
- R8: Raw interrupt bit 2 is set while the receive queue holds 4 or more words, bit 3 while the transmit queue holds 4 or fewer; masked status (0x1C) is raw AND mask, and `irq` is high exactly when masked status is non-zero.
- R9: A write to the clear register (0x20) never changes raw interrupt bits 2 and 3.
- R10: Reads from 0xFE0 to 0xFFF return 0x22, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 for successive words; the DMA control word (0x24) reads 0 whatever is written; the prescale register (0x10) keeps only 8 bits.
- R11: Outside loopback each word is framed by `cs_n` low, shifted MSB first with `sclk` idle low, `mosi` changing on falling edges and `miso` sampled on rising edges, one rising edge per bit; each `sclk` half period lasts max(1, prescale*(ctrl0[15:8]+1)/2) clock cycles.
- R12: While control register 1 bit 2 (slave select) is set no transfer starts, and all registers stay readable and writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_en | input | 1 | Register access strobe, one access per cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte address, bits [1:0] ignored |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid the cycle after the access |
| irq | output | 1 | Combined masked interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low word select |

## Verification
Two collisions matter: a data write pushing the transmit queue on the same edge that the loopback engine pops it, and a data read popping the receive queue on the same edge that the engine refills it after a stall. The first is provoked by a burst of writes on consecutive cycles with loopback on, the second by filling the receive queue, leaving words waiting in the transmit queue, then reading on consecutive cycles. Both are judged by the order and values of every word read back and by the status word after the burst, which must show no lost or duplicated word.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 12;
    localparam int DIV_W  = 17;

    // word addresses (byte address bits [11:2])
    localparam logic [9:0] WA_CFG_A  = 10'h000;
    localparam logic [9:0] WA_CFG_B  = 10'h001;
    localparam logic [9:0] WA_DATA   = 10'h002;
    localparam logic [9:0] WA_FLAGS  = 10'h003;
    localparam logic [9:0] WA_PSC    = 10'h004;
    localparam logic [9:0] WA_IENA   = 10'h005;
    localparam logic [9:0] WA_IRAW   = 10'h006;
    localparam logic [9:0] WA_IMSKD  = 10'h007;
    localparam logic [9:0] WA_ICLR   = 10'h008;
    localparam logic [9:0] WA_DMA    = 10'h009;
    localparam logic [ADDR_W-1:0] ID_BASE = 12'hFE0;

    typedef struct packed {
        logic out_off;
        logic slave;
        logic enable;
        logic loop;
    } cfg_b_t;

    typedef struct packed {
        logic busy;
        logic rx_full;
        logic rx_some;
        logic tx_room;
        logic tx_none;
    } flags_t;

    typedef struct packed {
        logic tx_low;
        logic rx_high;
        logic timeout;
        logic overrun;
    } ibits_t;

    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        case (idx)
            3'd0: id_byte = 8'h22;
            3'd1: id_byte = 8'h10;
            3'd2: id_byte = 8'h04;
            3'd3: id_byte = 8'h00;
            3'd4: id_byte = 8'h0D;
            3'd5: id_byte = 8'hF0;
            3'd6: id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] width_mask(input logic [3:0] code);
        logic [DATA_W:0] t;
        t = ({{DATA_W{1'b0}}, 1'b1} << ({1'b0, code} + 5'd1)) - {{DATA_W{1'b0}}, 1'b1};
        return t[DATA_W-1:0];
    endfunction

    function automatic logic [DIV_W-1:0] half_ticks(input logic [7:0] psc, input logic [7:0] scr);
        logic [DIV_W-1:0] prod;
        prod = DIV_W'(psc) * (DIV_W'(scr) + DIV_W'(1));
        prod = prod >> 1;
        if (prod == '0) prod = DIV_W'(1);
        return prod;
    endfunction

endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           push,
    input  logic [W-1:0]                   din,
    input  logic                           pop,
    output logic [W-1:0]                   head,
    output logic [$clog2(DEPTH+1)-1:0]     count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) begin
                mem[wp] <= din;
                wp      <= bump(wp);
            end
            if (pop) rp <= bump(rp);
            case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    assign head = mem[rp];

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |-> (count != FULL));
    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
        pop |-> (count != '0));

endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter
    import ssp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] word,
    input  logic [3:0]        width_code,
    input  logic [DIV_W-1:0]  half,
    input  logic              miso,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_word,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n
);
    localparam int BW = $clog2(DATA_W + 1);

    logic [DATA_W-1:0] tx_sh, rx_sh;
    logic [BW-1:0]     left;
    logic [DIV_W-1:0]  tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            sclk  <= 1'b0;
            cs_n  <= 1'b1;
            tx_sh <= '0;
            rx_sh <= '0;
            left  <= '0;
            tick  <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy  <= 1'b1;
                    cs_n  <= 1'b0;
                    sclk  <= 1'b0;
                    tick  <= '0;
                    left  <= BW'(width_code) + BW'(1);
                    tx_sh <= word << (4'd15 - width_code);
                    rx_sh <= '0;
                end
            end else if (tick == half - DIV_W'(1)) begin
                tick <= '0;
                if (!sclk) begin
                    sclk  <= 1'b1;
                    rx_sh <= {rx_sh[DATA_W-2:0], miso};
                end else begin
                    sclk  <= 1'b0;
                    tx_sh <= tx_sh << 1;
                    if (left == BW'(1)) begin
                        busy <= 1'b0;
                        cs_n <= 1'b1;
                        done <= 1'b1;
                    end else begin
                        left <= left - BW'(1);
                    end
                end
            end else begin
                tick <= tick + DIV_W'(1);
            end
        end
    end

    assign mosi    = tx_sh[DATA_W-1];
    assign rx_word = rx_sh;

    assert_sclk_framed_R11: assert property (@(posedge clk) disable iff (rst)
        sclk |-> !cs_n);
    assert_no_restart_R11: assert property (@(posedge clk) disable iff (rst)
        (busy && !cs_n) |=> (!cs_n || done));

endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
    import ssp_pkg::*;
#(
    parameter int FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_en,
    input  logic              reg_wr,
    input  logic [11:0]       reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    output logic              irq,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(FIFO_DEPTH);
    localparam logic [CW-1:0] HALF_CNT = CW'(FIFO_DEPTH / 2);

    logic [15:0] cfg_a;
    cfg_b_t      cfg_b;
    logic [7:0]  psc;
    ibits_t      ien;

    logic [DATA_W-1:0] mask;
    logic [9:0]        wa;
    logic              wr_hit, rd_hit;

    logic              tx_push, tx_pop, rx_push, rx_pop;
    logic [DATA_W-1:0] tx_head, rx_head, rx_din;
    logic [CW-1:0]     tx_cnt, rx_cnt;

    logic              can_move, lb_move, shf_start;
    logic              shf_busy, shf_done;
    logic [DATA_W-1:0] shf_rx;

    flags_t            flags;
    ibits_t            iraw;
    logic [15:0]       rd_mux;

    assign mask   = width_mask(cfg_a[3:0]);
    assign wa     = reg_addr[11:2];
    assign wr_hit = reg_en && reg_wr;
    assign rd_hit = reg_en && !reg_wr;

    // ---------------- configuration registers ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_a <= '0;
            cfg_b <= '0;
            psc   <= '0;
            ien   <= '0;
        end else if (wr_hit) begin
            case (wa)
                WA_CFG_A: cfg_a <= reg_wdata;
                WA_CFG_B: cfg_b <= cfg_b_t'(reg_wdata[3:0]);
                WA_PSC:   psc   <= reg_wdata[7:0];
                WA_IENA:  ien   <= ibits_t'(reg_wdata[3:0]);
                default:  ;
            endcase
        end
    end

    // ---------------- queues ----------------
    assign tx_push = wr_hit && (wa == WA_DATA) && (tx_cnt != FULL_CNT);
    assign rx_pop  = rd_hit && (wa == WA_DATA) && (rx_cnt != '0);

    ssp_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(rst),
        .push(tx_push), .din(reg_wdata & mask),
        .pop(tx_pop), .head(tx_head), .count(tx_cnt)
    );

    ssp_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(rst),
        .push(rx_push), .din(rx_din),
        .pop(rx_pop), .head(rx_head), .count(rx_cnt)
    );

    // ---------------- transfer engine ----------------
    assign can_move  = cfg_b.enable && !cfg_b.slave &&
                       (tx_cnt != '0) && (rx_cnt != FULL_CNT) &&
                       !shf_busy && !shf_done;
    assign lb_move   = can_move && cfg_b.loop;
    assign shf_start = can_move && !cfg_b.loop;

    ssp_shifter u_shf (
        .clk(clk), .rst(rst),
        .start(shf_start), .word(tx_head), .width_code(cfg_a[3:0]),
        .half(half_ticks(psc, cfg_a[15:8])), .miso(miso),
        .busy(shf_busy), .done(shf_done), .rx_word(shf_rx),
        .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
    );

    assign tx_pop  = lb_move || shf_done;
    assign rx_push = lb_move || shf_done;
    assign rx_din  = (lb_move ? tx_head : shf_rx) & mask;

    // ---------------- status and interrupts ----------------
    always_comb begin
        flags.tx_none = (tx_cnt == '0);
        flags.tx_room = (tx_cnt != FULL_CNT);
        flags.rx_some = (rx_cnt != '0);
        flags.rx_full = (rx_cnt == FULL_CNT);
        flags.busy    = (tx_cnt != '0);
        iraw.overrun  = 1'b0;
        iraw.timeout  = 1'b0;
        iraw.rx_high  = (rx_cnt >= HALF_CNT);
        iraw.tx_low   = (tx_cnt <= HALF_CNT);
    end

    assign irq = |(iraw & ien);

    // ---------------- read path ----------------
    always_comb begin
        rd_mux = '0;
        if (reg_addr >= ID_BASE) begin
            rd_mux = {8'h00, id_byte(reg_addr[4:2])};
        end else begin
            case (wa)
                WA_CFG_A:  rd_mux = cfg_a;
                WA_CFG_B:  rd_mux = {12'h000, cfg_b};
                WA_DATA:   rd_mux = (rx_cnt != '0) ? rx_head : '0;
                WA_FLAGS:  rd_mux = {11'h000, flags};
                WA_PSC:    rd_mux = {8'h00, psc};
                WA_IENA:   rd_mux = {12'h000, ien};
                WA_IRAW:   rd_mux = {12'h000, iraw};
                WA_IMSKD:  rd_mux = {12'h000, iraw & ien};
                default:   rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         reg_rdata <= '0;
        else if (rd_hit) reg_rdata <= rd_mux;
    end

    // ---------------- assertions ----------------
    assert_rx_never_overrun_R5: assert property (@(posedge clk) disable iff (rst)
        rx_push |-> (rx_cnt != FULL_CNT));
    assert_gate_closed_R3: assert property (@(posedge clk) disable iff (rst)
        (!cfg_b.enable && !shf_busy && !shf_done) |=> (tx_cnt >= $past(tx_cnt)));
    assert_slave_no_start_R12: assert property (@(posedge clk) disable iff (rst)
        cfg_b.slave |-> !shf_start);
    assert_tx_full_drop_R4: assert property (@(posedge clk) disable iff (rst)
        (tx_cnt == FULL_CNT) |=> (tx_cnt <= FULL_CNT));

endmodule

// File: tb/ssp_ctrl_bench.sv
module ssp_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_en = 1'b0, reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq, sclk, mosi, cs_n, miso;
    logic        ext_loop = 1'b0;
    logic        miso_level = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    assign miso = ext_loop ? mosi : miso_level;

    ssp_ctrl u_ssp_ctrl (
        .clk(clk), .rst(rst), .reg_en(reg_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    // observe serial line: bits on rising sclk while selected
    logic [15:0] cap = '0;
    int          rises = 0;
    always @(posedge sclk) begin
        if (!cs_n) begin
            cap   <= {cap[14:0], mosi};
            rises <= rises + 1;
        end
    end

    task automatic check(input string req, input string what, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_wr = 1'b0; reg_addr = a;
        @(posedge clk);
        #2 d = reg_rdata;
        @(negedge clk);
        reg_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        for (int i = 0; i < 400; i++) begin
            rd(12'h00C, s);
            if (!s[4]) break;
        end
        idle(4);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(12'h00C, v); check("R1", "status after reset", v, 16'h0003);
        rd(12'h018, v); check("R1", "raw irq after reset", v, 16'h0008);
        rd(12'h014, v); check("R1", "mask after reset", v, 16'h0000);
        check("R1", "irq after reset", {15'h0, irq}, 16'h0000);
        rd(12'h008, v); check("R4", "empty data read", v, 16'h0000);
    endtask

    task automatic t_gate();
        logic [15:0] v;
        wr(12'h000, 16'h0007);
        wr(12'h004, 16'h0000);
        wr(12'h008, 16'h0011); wr(12'h008, 16'h0022); wr(12'h008, 16'h0033);
        idle(20);
        rd(12'h00C, v); check("R3", "disabled keeps words queued", v, 16'h0012);
        check("R7", "busy with queued words", {15'h0, v[4]}, 16'h0001);
        wr(12'h004, 16'h0003);
        idle(6);
        rd(12'h00C, v); check("R7", "status after loopback drain", v, 16'h0007);
        rd(12'h008, v); check("R6", "loopback word 0", v, 16'h0011);
        rd(12'h008, v); check("R6", "loopback word 1", v, 16'h0022);
        rd(12'h008, v); check("R6", "loopback word 2", v, 16'h0033);
        rd(12'h008, v); check("R4", "read after drain", v, 16'h0000);
    endtask

    task automatic t_mask();
        logic [15:0] v;
        wr(12'h000, 16'h0003);
        wr(12'h008, 16'h00AB);
        idle(4);
        rd(12'h008, v); check("R2", "4-bit width", v, 16'h000B);
        wr(12'h000, 16'h000F);
        rd(12'h000, v); check("R2", "cfg readback", v, 16'h000F);
        wr(12'h008, 16'hBEEF);
        idle(4);
        rd(12'h008, v); check("R2", "16-bit width", v, 16'hBEEF);
        wr(12'h000, 16'h0007);
    endtask

    task automatic t_full();
        logic [15:0] v;
        wr(12'h004, 16'h0000);
        for (int i = 0; i < 9; i++) wr(12'h008, 16'h0010 + 16'(i));
        rd(12'h00C, v); check("R4", "tx full status", v, 16'h0010);
        wr(12'h004, 16'h0003);
        idle(12);
        rd(12'h00C, v); check("R5", "rx full status", v, 16'h000F);
        for (int i = 0; i < 8; i++) begin
            rd(12'h008, v); check("R4", "ninth write dropped, order", v, 16'h0010 + 16'(i));
        end
        rd(12'h008, v); check("R4", "no ninth word", v, 16'h0000);
    endtask

    // burst write then burst read: collisions of push/pop with engine
    task automatic t_collide();
        logic [15:0] v;
        logic [15:0] got [10];
        @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            reg_en = 1'b1; reg_wr = 1'b1; reg_addr = 12'h008; reg_wdata = 16'h0020 + 16'(i);
            @(negedge clk);
        end
        reg_en = 1'b0; reg_wr = 1'b0;
        idle(6);
        rd(12'h00C, v); check("R5", "stalled with two waiting", v, 16'h001E);
        @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            reg_en = 1'b1; reg_wr = 1'b0; reg_addr = 12'h008;
            @(posedge clk);
            #2 got[i] = reg_rdata;
            @(negedge clk);
        end
        reg_en = 1'b0;
        for (int i = 0; i < 10; i++)
            check("R5", "burst order", got[i], 16'h0020 + 16'(i));
        rd(12'h00C, v); check("R7", "empty after burst", v, 16'h0003);
    endtask

    task automatic t_irq();
        logic [15:0] v;
        wr(12'h004, 16'h0000);
        wr(12'h014, 16'h0008);
        idle(1);
        check("R8", "irq tx low", {15'h0, irq}, 16'h0001);
        for (int i = 0; i < 5; i++) wr(12'h008, 16'h0040 + 16'(i));
        rd(12'h018, v); check("R8", "raw with five queued", v, 16'h0000);
        check("R8", "irq off", {15'h0, irq}, 16'h0000);
        wr(12'h020, 16'h000F);
        rd(12'h018, v); check("R9", "clear ignored (tx)", v, 16'h0000);
        wr(12'h004, 16'h0003);
        idle(8);
        rd(12'h018, v); check("R8", "raw rx high tx low", v, 16'h000C);
        wr(12'h014, 16'h0004);
        rd(12'h01C, v); check("R8", "masked view", v, 16'h0004);
        check("R8", "irq rx", {15'h0, irq}, 16'h0001);
        wr(12'h020, 16'h000F);
        rd(12'h018, v); check("R9", "clear ignored (rx)", v, 16'h000C);
        wr(12'h014, 16'h0000);
        idle(1);
        check("R8", "irq masked off", {15'h0, irq}, 16'h0000);
        for (int i = 0; i < 5; i++) rd(12'h008, v);
        rd(12'h018, v); check("R8", "rx below half", v, 16'h0008);
    endtask

    task automatic t_ident();
        logic [15:0] v;
        logic [7:0] ids [8] = '{8'h22, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        for (int i = 0; i < 8; i++) begin
            rd(12'hFE0 + 12'(4 * i), v); check("R10", "id byte", v, {8'h00, ids[i]});
        end
        wr(12'h024, 16'hFFFF);
        rd(12'h024, v); check("R10", "dma reads zero", v, 16'h0000);
        wr(12'h010, 16'h01FF);
        rd(12'h010, v); check("R10", "prescale 8 bits", v, 16'h00FF);
    endtask

    task automatic t_slave();
        logic [15:0] v;
        wr(12'h004, 16'h0006);
        wr(12'h008, 16'h0051); wr(12'h008, 16'h0052);
        idle(20);
        rd(12'h00C, v); check("R12", "slave blocks transfer", v, 16'h0012);
        rd(12'h004, v); check("R12", "cfg readable", v, 16'h0006);
        wr(12'h004, 16'h0003);
        idle(6);
        rd(12'h008, v); check("R12", "drain word 0", v, 16'h0051);
        rd(12'h008, v); check("R12", "drain word 1", v, 16'h0052);
    endtask

    task automatic t_serial();
        logic [15:0] v;
        int r0;
        wr(12'h000, 16'h0007);
        wr(12'h010, 16'h0002);
        ext_loop = 1'b1;
        check("R11", "cs idle high", {15'h0, cs_n}, 16'h0001);
        wr(12'h004, 16'h0002);
        r0 = rises;
        wr(12'h008, 16'h00A5);
        wait_idle();
        check("R11", "MSB-first on mosi", {8'h00, cap[7:0]}, 16'h00A5);
        check("R11", "one rising edge per bit", 16'(rises - r0), 16'd8);
        wr(12'h008, 16'h003C);
        wait_idle();
        check("R11", "second word on mosi", {8'h00, cap[7:0]}, 16'h003C);
        rd(12'h008, v); check("R6", "serial echo 0", v, 16'h00A5);
        rd(12'h008, v); check("R6", "serial echo 1", v, 16'h003C);
        ext_loop = 1'b0; miso_level = 1'b1;
        wr(12'h000, 16'h0105);
        wr(12'h008, 16'h0000);
        wait_idle();
        rd(12'h008, v); check("R6", "miso high, 6-bit", v, 16'h003F);
        check("R11", "cs released", {15'h0, cs_n}, 16'h0001);
        wr(12'h004, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle(2);
        t_reset();
        t_gate();
        t_mask();
        t_full();
        t_collide();
        t_irq();
        t_ident();
        t_slave();
        t_serial();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule